// File: doc/BRIEF.md
# Expansion Cartridge ROM Switch Controller

This block is the glue logic of an expansion cartridge for an 8-bit host. It holds three 8-bit I/O ports, each with a direction register, decoded in one I/O page of the host. Two bits of the third port steer ROM mapping. One bit raises the host's external-ROM request. The other bit decides where the host's low-ROM select goes: to the on-board ROM, or on to a second, stacked cartridge slot. A third bit of that port senses whether a second cartridge is present.

After reset every port line is an input. The two steering lines then read as pulled high, so the on-board ROM maps in without any software action. Initialization code can later turn the ROM off by making those bits outputs and clearing them. Register writes are qualified by the high phase of the bus clock, so no write can land outside the valid part of a bus cycle.

Top module: `cart_rom_switch`

## Requirements
- R1: A synchronous active-high `rst` clears every port latch and every direction register to 0, so every output enable is low.
- R2: `exrom_n` is the inverse of the effective port C bit 3. An effective bit is the latch bit when its direction bit is 1, and 1 (pull-up) when its direction bit is 0.
- R3: `rom_cs_n` is low exactly when `roml_n` is low and effective port C bit 4 is 1.
- R4: `slot2_roml_n` equals `roml_n` while effective port C bit 4 is 0, and is held at 1 while it is 1.
- R5: Offsets 0, 1 and 2 read ports A, B and C. Each bit returns the latch where its direction bit is 1 and the pin where it is 0. Offsets 3, 4 and 5 read the A, B and C direction registers. Port C pins 3 and 4 read 1, port C pin 7 reads `slot2_exrom_n`, and the other port C pins read `pc_in`.
- R6: A write is recognised only in clock cycles where `io_sel_n` is 0, `rw` is 0 (write) and `phi` is 1. No other cycle changes any register.
- R7: A write takes effect at the first clock edge at which the qualified strobe is found low after being high. It uses the address and data sampled on the last edge at which the strobe was high. The new register value is visible only after that edge.
- R8: `rdata` is combinational from `addr` while `io_sel_n` is 0 and `rw` is 1, and is 0 at all other times. Offsets 6 and 7 read 0, and writes to them change nothing.
- R9: `pa_out`, `pb_out` and `pc_out` show the A, B and C latches. `pa_oe`, `pb_oe` and `pc_oe` show the A, B and C direction registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel_n | input | 1 | Host I/O page strobe, active low, used as register select |
| rw | input | 1 | Bus direction, 1 read, 0 write |
| phi | input | 1 | Bus clock phase; writes qualify only while high |
| addr | input | 3 | Register offset within the page |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| roml_n | input | 1 | Host low-ROM select, active low |
| exrom_n | output | 1 | External-ROM request to the host, active low |
| rom_cs_n | output | 1 | On-board ROM chip select, active low |
| slot2_exrom_n | input | 1 | External-ROM request of the second slot; low means a cartridge is present |
| slot2_roml_n | output | 1 | Low-ROM select passed to the second slot |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs for the general bits |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench first checks the state right after reset. If the steering bits read as 0 instead of pulled high, the ROM would stay unmapped and the host would never find the cartridge. Writes issued while `phi` is low must leave every register unchanged; a design that ignored the phase would take the spurious writes the qualification exists to block. A strobe held high over several clocks must not change any output until it falls, and a design that committed early would show the new value a cycle or more too soon. The bench also covers readback with mixed direction bits, the sense bit with and without a second cartridge, and writes to the unused offsets 6 and 7. A wrong merge or a missing address guard shows up as corrupted read data or port values.

// File: rtl/cart_pkg.sv
package cart_pkg;

    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int NPORT = 3;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_req_t;

    typedef logic [NPORT-1:0][DW-1:0] port_arr_t;

    function automatic logic [DW-1:0] merge_pins(
        input logic [DW-1:0] lat,
        input logic [DW-1:0] dir,
        input logic [DW-1:0] pin
    );
        return (lat & dir) | (pin & ~dir);
    endfunction

endpackage

// File: rtl/cart_bus_strobe.sv
module cart_bus_strobe
    import cart_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          io_sel_n,
    input  logic          rw,
    input  logic          phi,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output wr_req_t       req,
    output logic          wr_pulse
);

    logic stb;
    logic stb_q;

    assign stb = !io_sel_n && !rw && phi;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= 1'b0;
            req   <= '0;
        end else begin
            stb_q <= stb;
            if (stb) begin
                req.addr <= addr;
                req.data <= wdata;
            end
        end
    end

    // commit when the sampled strobe has fallen
    assign wr_pulse = stb_q && !stb;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse); // R7

endmodule

// File: rtl/cart_port_regs.sv
module cart_port_regs
    import cart_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_pulse,
    input  wr_req_t       req,
    input  logic [AW-1:0] rd_addr,
    input  port_arr_t     pins,
    output port_arr_t     lat_q,
    output port_arr_t     dir_q,
    output logic [DW-1:0] rd_val
);

    port_arr_t view;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            dir_q <= '0;
        end else if (wr_pulse) begin
            for (int p = 0; p < NPORT; p++) begin
                if (req.addr == AW'(p))         lat_q[p] <= req.data;
                if (req.addr == AW'(NPORT + p)) dir_q[p] <= req.data;
            end
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_view
        assign view[g] = merge_pins(lat_q[g], dir_q[g], pins[g]);
    end

    always_comb begin
        rd_val = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (rd_addr == AW'(p))         rd_val = view[p];
            if (rd_addr == AW'(NPORT + p)) rd_val = dir_q[p];
        end
    end

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_pulse |=> ($stable(lat_q) && $stable(dir_q))); // R6

    AST_RESET_ALL_INPUT: assert property (@(posedge clk)
        $past(rst) |-> (dir_q == '0 && lat_q == '0)); // R1

endmodule

// File: rtl/cart_rom_select.sv
module cart_rom_select (
    input  logic roml_n,
    input  logic map_req,
    input  logic rom_en,
    output logic exrom_n,
    output logic rom_cs_n,
    output logic slot2_roml_n
);

    assign exrom_n      = !map_req;
    assign rom_cs_n     = roml_n || !rom_en;
    assign slot2_roml_n = rom_en ? 1'b1 : roml_n;

endmodule

// File: rtl/cart_rom_switch.sv
module cart_rom_switch
    import cart_pkg::*;
#(
    parameter int MAP_BIT   = 3,
    parameter int EN_BIT    = 4,
    parameter int SENSE_BIT = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          io_sel_n,
    input  logic          rw,
    input  logic          phi,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          roml_n,
    output logic          exrom_n,
    output logic          rom_cs_n,
    input  logic          slot2_exrom_n,
    output logic          slot2_roml_n,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);

    localparam int PC = NPORT - 1;

    wr_req_t       req;
    logic          wr_pulse;
    port_arr_t     pins;
    port_arr_t     lat_q;
    port_arr_t     dir_q;
    logic [DW-1:0] pc_raw;
    logic [DW-1:0] pc_eff;
    logic [DW-1:0] rd_val;

    cart_bus_strobe u_strobe (
        .clk      (clk),
        .rst      (rst),
        .io_sel_n (io_sel_n),
        .rw       (rw),
        .phi      (phi),
        .addr     (addr),
        .wdata    (wdata),
        .req      (req),
        .wr_pulse (wr_pulse)
    );

    // port C pins: steering lines pulled high, sense line from slot 2
    for (genvar i = 0; i < DW; i++) begin : g_pc_pin
        if (i == MAP_BIT || i == EN_BIT) begin : g_pull
            assign pc_raw[i] = 1'b1;
        end else if (i == SENSE_BIT) begin : g_sense
            assign pc_raw[i] = slot2_exrom_n;
        end else begin : g_gen
            assign pc_raw[i] = pc_in[i];
        end
    end

    assign pins[0]  = pa_in;
    assign pins[1]  = pb_in;
    assign pins[PC] = pc_raw;

    cart_port_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_pulse (wr_pulse),
        .req      (req),
        .rd_addr  (addr),
        .pins     (pins),
        .lat_q    (lat_q),
        .dir_q    (dir_q),
        .rd_val   (rd_val)
    );

    assign pc_eff = merge_pins(lat_q[PC], dir_q[PC], pc_raw);

    cart_rom_select u_sel (
        .roml_n       (roml_n),
        .map_req      (pc_eff[MAP_BIT]),
        .rom_en       (pc_eff[EN_BIT]),
        .exrom_n      (exrom_n),
        .rom_cs_n     (rom_cs_n),
        .slot2_roml_n (slot2_roml_n)
    );

    assign rdata  = (!io_sel_n && rw) ? rd_val : '0;
    assign pa_out = lat_q[0];
    assign pa_oe  = dir_q[0];
    assign pb_out = lat_q[1];
    assign pb_oe  = dir_q[1];
    assign pc_out = lat_q[PC];
    assign pc_oe  = dir_q[PC];

    AST_WRITE_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> ($past(phi) && !$past(io_sel_n) && !$past(rw))); // R6

    AST_DEFAULT_MAPS_IN: assert property (@(posedge clk) disable iff (rst)
        !dir_q[PC][MAP_BIT] |-> !exrom_n); // R2

    AST_ROM_NEEDS_ROML: assert property (@(posedge clk) disable iff (rst)
        !rom_cs_n |-> !roml_n); // R3

    AST_ONE_ROM_TARGET: assert property (@(posedge clk) disable iff (rst)
        !rom_cs_n |-> slot2_roml_n); // R4

endmodule

// File: tb/test_cart_rom_switch.sv
module test_cart_rom_switch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_sel_n = 1'b1, rw = 1'b1, phi = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       roml_n = 1'b0;
    logic       exrom_n, rom_cs_n, slot2_roml_n;
    logic       slot2_exrom_n = 1'b1;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int failures = 0;
    bit live = 0;

    always #10 clk = ~clk;

    cart_rom_switch i_cart_rom_switch (
        .clk(clk), .rst(rst), .io_sel_n(io_sel_n), .rw(rw), .phi(phi),
        .addr(addr), .wdata(wdata), .rdata(rdata), .roml_n(roml_n),
        .exrom_n(exrom_n), .rom_cs_n(rom_cs_n), .slot2_exrom_n(slot2_exrom_n),
        .slot2_roml_n(slot2_roml_n), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
        .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // behavioural reference model
    logic [7:0] m_lat [3];
    logic [7:0] m_dir [3];
    bit         m_stb_q = 0;
    logic [2:0] m_cap_a = '0;
    logic [7:0] m_cap_d = '0;

    always @(posedge clk) begin
        bit s;
        if (rst) begin
            for (int k = 0; k < 3; k++) begin m_lat[k] = 0; m_dir[k] = 0; end
            m_stb_q = 0; m_cap_a = 0; m_cap_d = 0;
        end else begin
            s = (io_sel_n == 0) && (rw == 0) && (phi == 1);
            if (m_stb_q && !s) begin
                if (m_cap_a < 3) m_lat[m_cap_a] = m_cap_d;
                else if (m_cap_a < 6) m_dir[m_cap_a - 3] = m_cap_d;
            end
            m_stb_q = s;
            if (s) begin m_cap_a = addr; m_cap_d = wdata; end
        end
    end

    function automatic logic [7:0] pin_of(int p);
        logic [7:0] v;
        if (p == 0) return pa_in;
        if (p == 1) return pb_in;
        v = pc_in;
        v[3] = 1'b1;
        v[4] = 1'b1;
        v[7] = slot2_exrom_n;
        return v;
    endfunction

    function automatic logic [7:0] view_of(int p);
        return (m_lat[p] & m_dir[p]) | (pin_of(p) & ~m_dir[p]);
    endfunction

    function automatic logic [7:0] exp_rdata();
        if (!(io_sel_n == 0 && rw == 1)) return 8'h00;
        if (addr < 3) return view_of(int'(addr));
        if (addr < 6) return m_dir[addr - 3];
        return 8'h00;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [7:0] pc_e;
        if (live) begin
            pc_e = view_of(2);
            check("R9 pa_out", pa_out, m_lat[0]);
            check("R9 pa_oe",  pa_oe,  m_dir[0]);
            check("R9 pb_out", pb_out, m_lat[1]);
            check("R9 pb_oe",  pb_oe,  m_dir[1]);
            check("R9 pc_out", pc_out, m_lat[2]);
            check("R9 pc_oe",  pc_oe,  m_dir[2]);
            check("R2 exrom_n", {7'b0, exrom_n}, {7'b0, ~pc_e[3]});
            check("R3 rom_cs_n", {7'b0, rom_cs_n}, {7'b0, ~(~roml_n & pc_e[4])});
            check("R4 slot2_roml_n", {7'b0, slot2_roml_n}, {7'b0, pc_e[4] ? 1'b1 : roml_n});
            check((io_sel_n == 0 && rw == 1) ? "R5 rdata" : "R8 rdata", rdata, exp_rdata());
        end
    end

    task automatic idle();
        io_sel_n = 1; rw = 1; phi = 0;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d, logic ph);
        @(posedge clk); #2;
        io_sel_n = 0; rw = 0; phi = ph; addr = a; wdata = d;
        @(posedge clk); #2;
        idle();
        @(posedge clk); #2;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(posedge clk); #2;
        io_sel_n = 0; rw = 1; phi = 1; addr = a;
        @(negedge clk);
        d = rdata;
        @(posedge clk); #2;
        idle();
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        #2 rst = 0;
        live = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 pa_oe", pa_oe, 8'h00);
        check("R1 pc_oe", pc_oe, 8'h00);
        check("R2 default exrom_n", {7'b0, exrom_n}, 8'h00);
        check("R3 default rom_cs_n", {7'b0, rom_cs_n}, 8'h00);
        check("R4 default slot2_roml_n", {7'b0, slot2_roml_n}, 8'h01);
        rd(3'd5, v); check("R1 dir C read", v, 8'h00);

        // R7: strobe held several clocks, no commit before it falls
        @(posedge clk); #2;
        io_sel_n = 0; rw = 0; phi = 1; addr = 3'd3; wdata = 8'hAA;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 before fall pa_oe", pa_oe, 8'h00);
        #8 idle();
        @(negedge clk);
        check("R7 after fall pa_oe", pa_oe, 8'hAA);

        // R6: writes with phi low are ignored
        wr(3'd0, 8'hFF, 1'b0);
        @(negedge clk);
        check("R6 phi low pa_out", pa_out, 8'h00);

        // R5: mixed direction readback
        pa_in = 8'h0F;
        wr(3'd0, 8'hF0, 1'b1);
        rd(3'd0, v); check("R5 port A mix", v, 8'hA5);

        // R9: port B
        wr(3'd4, 8'h0F, 1'b1);
        wr(3'd1, 8'h3C, 1'b1);
        @(negedge clk);
        check("R9 pb_out", pb_out, 8'h3C);
        check("R9 pb_oe", pb_oe, 8'h0F);

        // ROM steering
        roml_n = 0;
        wr(3'd5, 8'h18, 1'b1);
        @(negedge clk);
        check("R2 map off", {7'b0, exrom_n}, 8'h01);
        check("R3 rom off", {7'b0, rom_cs_n}, 8'h01);
        check("R4 pass low", {7'b0, slot2_roml_n}, 8'h00);
        roml_n = 1;
        @(negedge clk);
        check("R4 pass high", {7'b0, slot2_roml_n}, 8'h01);
        roml_n = 0;
        wr(3'd2, 8'h10, 1'b1);
        @(negedge clk);
        check("R3 rom on", {7'b0, rom_cs_n}, 8'h00);
        check("R4 blocked", {7'b0, slot2_roml_n}, 8'h01);
        check("R2 bit3 low", {7'b0, exrom_n}, 8'h01);
        wr(3'd2, 8'h18, 1'b1);
        @(negedge clk);
        check("R2 map on", {7'b0, exrom_n}, 8'h00);

        // R5: sense bit
        pc_in = 8'h00;
        slot2_exrom_n = 0;
        rd(3'd2, v); check("R5 sense present", v, 8'h18);
        slot2_exrom_n = 1;
        rd(3'd2, v); check("R5 sense absent", v, 8'h98);
        wr(3'd5, 8'h00, 1'b1);
        pc_in = 8'h21;
        rd(3'd2, v); check("R5 pull-ups", v, 8'hB9);

        // R8: unused offsets and deselected reads
        wr(3'd6, 8'h77, 1'b1);
        wr(3'd7, 8'h55, 1'b1);
        rd(3'd6, v); check("R8 offset 6", v, 8'h00);
        rd(3'd3, v); check("R8 dir A intact", v, 8'hAA);
        @(negedge clk);
        check("R8 deselected", rdata, 8'h00);

        repeat (3) @(posedge clk);
        #2 rst = 1;
        @(posedge clk); #2 rst = 0;
        @(negedge clk);
        check("R1 re-reset pb_oe", pb_oe, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule